// File: doc/BRIEF.md
# Attenuation State Controller

This block holds the 7-bit control word of a binary-weighted step attenuator. Bit i of the word switches in 0.25 dB × 2^i, so the word equals the attenuation in quarter-decibel units. A value of 0 is the insertion-loss reference. A value of 127 is 31.75 dB.

A mode input chooses where the word comes from. When it is low, the word comes from seven parallel pins, gated by an enable line. The enable line gives two modes. If it is held high, the state tracks the pins (direct use). If it is pulsed, the state captures the pins while the line is high and freezes when it falls (latched use). When the mode input is high, the word comes from an already deserialised 8-bit serial word that arrives with a load strobe. Bit 7 of that word must be zero in normal use.

After reset the block sits at full attenuation. Parallel updates are blocked for a programmable number of clock cycles, so that direct use takes up its pin preset only after a delay. The block also raises a sticky flag when the one-time mode-switch sequencing is broken.

Top module: `step_atten_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `atten` is 127 (all ones) and `seq_err` is 0. This holds whatever the mode.
- R2: `atten` bit i carries 0.25 dB × 2^i. The register value therefore equals the attenuation in dB multiplied by four, and 127 means 31.75 dB.
- R3: In parallel mode (`ser_sel` = 0) with `le` high and the start-up hold expired, `atten` equals the `par_bits` sampled at the previous clock edge.
- R4: In parallel mode with `le` low, `atten` holds its value, however `par_bits` changes. The value it holds is the last one captured while `le` was high.
- R5: For `PRESET_CYCLES` clock edges after reset release, the parallel path cannot change `atten`, even with `le` high. The first parallel update happens at edge `PRESET_CYCLES`+1.
- R6: In serial mode (`ser_sel` = 1), `ser_load` high makes `atten` equal `ser_word[6:0]` one edge later. Without `ser_load`, `atten` holds its value, whatever `par_bits` and `le` do.
- R7: `ser_load` has no effect while `ser_sel` is low.
- R8: A high-to-low change of `ser_sel` sets `seq_err` when the stored serial bit 7 is 1. The stored bit 7 is bit 7 of the last serial word loaded. It counts as 1 until the first serial load.
- R9: A low-to-high change of `ser_sel` sets `seq_err` when any `par_bits` bit is 1. This check applies only until the first serial load whose bit 7 is 0.
- R10: After that first valid serial load, entering serial mode with non-zero pins sets no flag. Once set, `seq_err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ser_sel | input | 1 | Source select: 0 parallel pins, 1 serial word |
| le | input | 1 | Parallel enable: high = transparent, low = hold |
| par_bits | input | 7 | Parallel attenuation pins, quarter-dB binary weights |
| ser_word | input | 8 | Deserialised serial word; bit 7 must be 0 |
| ser_load | input | 1 | One-cycle strobe that applies `ser_word` |
| atten | output | 7 | Registered attenuation state |
| seq_err | output | 1 | Sticky mode-sequencing error |

## Verification
Every result is due one rising edge after the inputs that cause it: the state update for a serial load or a transparent parallel sample, and the flag for a mode change. The hold window is the exception. It releases the parallel path only at edge `PRESET_CYCLES`+1 after reset. The bench drives inputs on the falling edge and reads the outputs on the next falling edge, so exactly one register stage lies between stimulus and sample. For the hold window it counts falling edges from reset release and samples once well inside the window and once after it. The direct-mode sweep covers all 128 pin codes and the serial sweep covers all 256 words. Each expected value is computed from the quarter-dB weights.

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl #(
  parameter int STATE_W       = 7,
  parameter int PRESET_CYCLES = 20000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_sel,
  input  logic               le,
  input  logic [STATE_W-1:0] par_bits,
  input  logic [STATE_W:0]   ser_word,
  input  logic               ser_load,
  output logic [STATE_W-1:0] atten,
  output logic               seq_err
);
  localparam int CNT_W = $clog2(PRESET_CYCLES + 2);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(PRESET_CYCLES);

  logic [CNT_W-1:0] hold_cnt;
  logic ser_b7, seq_done, sel_q;

  wire hold_done = (hold_cnt == CNT_END);
  wire take_ser  = ser_sel & ser_load;
  wire take_par  = ~ser_sel & le & hold_done;
  wire sel_rise  = ser_sel & ~sel_q;
  wire sel_fall  = ~ser_sel & sel_q;
  wire bad_rise  = sel_rise & ~seq_done & (|par_bits);
  wire bad_fall  = sel_fall & ser_b7;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      atten    <= '1;
      ser_b7   <= 1'b1;
      seq_done <= 1'b0;
      sel_q    <= 1'b0;
      seq_err  <= 1'b0;
    end else begin
      if (!hold_done) hold_cnt <= hold_cnt + 1'b1;
      sel_q <= ser_sel;
      if (take_ser) begin
        atten  <= ser_word[STATE_W-1:0];
        ser_b7 <= ser_word[STATE_W];
        if (!ser_word[STATE_W]) seq_done <= 1'b1;
      end else if (take_par) begin
        atten <= par_bits;
      end
      if (bad_rise || bad_fall) seq_err <= 1'b1;
    end
  end

  a_r5_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_done && !take_ser) |=> $stable(atten));
  a_r3_direct_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_done && !ser_sel && le) |=> atten == $past(par_bits));
  a_r4_latched_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_sel && !le) |=> $stable(atten));
  a_r6_serial_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_sel && ser_load) |=> atten == $past(ser_word[STATE_W-1:0]));
  a_r6_serial_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_sel && !ser_load) |=> $stable(atten));
  a_r9_rise_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_sel && !sel_q && !seq_done && (|par_bits)) |=> seq_err);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);
endmodule

// File: tb/step_atten_ctrl_test.sv
module step_atten_ctrl_test;
  localparam int PRE = 16;
  logic clk = 0, rst_n = 0, ser_sel = 0, le = 1, ser_load = 0;
  logic [6:0] par_bits = 7'h15;
  logic [7:0] ser_word = 8'h00;
  logic [6:0] atten;
  logic seq_err;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  step_atten_ctrl #(.STATE_W(7), .PRESET_CYCLES(PRE)) uut (
    .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .le(le), .par_bits(par_bits),
    .ser_word(ser_word), .ser_load(ser_load), .atten(atten), .seq_err(seq_err));

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int quarter_db(input logic [6:0] code);
    int cdb = 0;
    for (int i = 0; i < 7; i++) if (code[i]) cdb += 25 * (1 << i);
    return cdb / 25;
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    tick(3);
    chk("R1 reset state", atten, 127);
    chk("R1 reset flag", seq_err, 0);
    rst_n = 1;
    tick(8);
    chk("R5 hold window keeps full", atten, 127);
    tick(12);
    chk("R3 direct preset after window", atten, 7'h15);
    for (int q = 0; q < 128; q++) begin
      par_bits = 7'(q);
      tick(1);
      chk("R2/R3 direct sweep", atten, quarter_db(7'(q)));
    end
    le = 0; par_bits = 7'h33; tick(3);
    chk("R4 latched hold", atten, 127);
    le = 1; par_bits = 7'h40; tick(1);
    le = 0; par_bits = 7'h01; tick(2);
    chk("R4 latched capture", atten, 7'h40);
    ser_load = 1; ser_word = 8'h05; tick(1);
    ser_load = 0; tick(1);
    chk("R7 load ignored in parallel", atten, 7'h40);
    ser_sel = 1; tick(1);
    chk("R9 rise with pins set", seq_err, 1);
    ser_sel = 0; par_bits = 0; tick(3);
    chk("R10 flag sticky", seq_err, 1);

    rst_n = 0; le = 0; tick(2);
    chk("R1 flag cleared", seq_err, 0);
    rst_n = 1; tick(PRE + 4);
    chk("R1 latched power-up full", atten, 127);
    ser_sel = 1; tick(1);
    chk("R9 clean rise", seq_err, 0);
    for (int w = 0; w < 256; w++) begin
      ser_word = 8'(w); ser_load = 1; le = w[0]; par_bits = 7'(~w);
      tick(1);
      chk("R6 serial sweep", atten, w & 127);
    end
    ser_load = 0; par_bits = 7'h0F; le = 1; tick(3);
    chk("R6 serial hold ignores pins", atten, 127);
    ser_word = 8'h2A; ser_load = 1; tick(1);
    ser_load = 0; tick(1);
    ser_sel = 0; le = 0; tick(1);
    chk("R8 clean fall", seq_err, 0);
    chk("R4 hold after mode switch", atten, 7'h2A);
    par_bits = 7'h7F; ser_sel = 1; tick(1);
    chk("R10 rise after sequencing", seq_err, 0);
    ser_word = 8'h91; ser_load = 1; tick(1);
    ser_load = 0;
    chk("R6 load with bit7", atten, 7'h11);
    ser_sel = 0; tick(1);
    chk("R8 fall with bit7 set", seq_err, 1);

    rst_n = 0; ser_sel = 1; par_bits = 0; tick(2);
    rst_n = 1; tick(4);
    chk("R1 serial power-up full", atten, 127);
    chk("R9 no rise at serial power-up", seq_err, 0);
    ser_sel = 0; tick(1);
    chk("R8 fall before any load", seq_err, 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule